// File: doc/BRIEF.md
# Pointer-Based Host Register Port

This block connects an 8-bit host processor to a 64-entry internal register file over a narrow asynchronous parallel bus. The bus has active-low chip select, read and write strobes, and an 8-bit data path. A single shared pin either selects between pointer and data (indexed mode) or latches an address from the data lines (address-latch mode). Two static mode inputs pick the bus style. The serial encodings are left to another block, so this port stays silent for them.

The port holds a 6-bit address pointer, a write-data holding register and a read-data prefetch register. The register file is addressed by the pointer at all times. Host reads return the prefetch register, which is refreshed from the register file after three events: a pointer load, a data read and a data write. The pointer never advances by itself, so one pointer load followed by a run of data reads or writes gives burst access to a single register, such as a FIFO data port.

All strobes and the bus value are passed through a synchronizer pipeline in the core clock domain. A write reaches the register file only once the write strobe has been seen to rise again.

Top module: `host_reg_port`

## Requirements
- R1: After reset the pointer (`rf_addr`) is 0, the prefetch register reads 0x00, no register-file strobe is active and the data bus is not driven.
- R2: `bus_oe` is high only while `cs_n` and `rd_n` are both low and the mode is parallel (`mode_sel[1]` = 0).
- R3: In indexed mode (`mode_sel` = 00), a write with `a0_ale` = 1 loads the low 6 bits of the bus into the pointer, and the prefetch register is reloaded from the newly addressed register.
- R4: In indexed mode, a write with `a0_ale` = 0 stores the bus byte into the register at the pointer with exactly one `rf_we` pulse, issued only after the write strobe has been released.
- R5: After each data write the prefetch register is reloaded, so the next data read returns the value just written.
- R6: A data read returns the prefetch register as it was before the read, and the prefetch register is reloaded after the read ends. A register that changed since the last reload is therefore seen on the following read.
- R7: Data reads and writes never change the pointer, so repeated data accesses after one pointer load all target the same register and leave its neighbours untouched.
- R8: In address-latch mode (`mode_sel` = 01), the bus value present while `a0_ale` is high is taken as the pointer when `a0_ale` falls. Each later read or write strobe then transfers data at that pointer, with the same reload rules as R5 and R6.
- R9: With `mode_sel[1]` = 1 (serial encodings 10 and 11), all strobes are ignored: no register-file strobe, no pointer change and no bus drive.
- R10: Strobes given while `cs_n` is high cause no register write, no pointer change and no reload.
- R11: A read with `a0_ale` = 1 in indexed mode is a reserved access that causes no prefetch reload (`rf_re` stays low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Static bus style: 00 indexed, 01 address-latch, 1x serial (ignored) |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| a0_ale | input | 1 | Pointer/data select (indexed) or address latch (address-latch) |
| bus_in | input | 8 | Data bus value from the pads |
| bus_out | output | 8 | Data bus value to the pads (prefetch register) |
| bus_oe | output | 1 | Pad output enable for the data bus |
| rf_addr | output | 6 | Register-file address (the pointer) |
| rf_wdata | output | 8 | Register-file write data |
| rf_we | output | 1 | Register-file write strobe, one cycle |
| rf_re | output | 1 | Register-file read strobe; the prefetch register loads `rf_rdata` on the next edge |
| rf_rdata | input | 8 | Register-file read data for `rf_addr`, combinational |

## Verification
The hardest case to create from the ports is a stale prefetch. The register behind the pointer has to change without any host access, so that the bench can tell the value read now from the value reloaded afterwards. The bench memory model has a side port that lets a task overwrite one entry between two host reads. The first read must return the old byte and the second the new one. A write-pulse counter watched while the write strobe is held low for several cycles shows that the commit waits for the strobe to rise.

// File: rtl/host_reg_port.sv
module host_reg_port #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              a0_ale,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              rf_re,
  input  logic [DATA_W-1:0] rf_rdata
);

  localparam int PW    = DATA_W + 4;
  localparam int DEPTH = SYNC_STAGES + 1;
  localparam int B_CS  = PW - 1;
  localparam int B_RD  = PW - 2;
  localparam int B_WR  = PW - 3;
  localparam int B_A   = PW - 4;
  localparam logic [PW-1:0] IDLE = {3'b111, 1'b0, {DATA_W{1'b0}}};

  logic [PW-1:0] pipe [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= IDLE;
    end else begin
      pipe[0] <= {cs_n, rd_n, wr_n, a0_ale, bus_in};
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  logic cur_rd, cur_wr, cur_a, prv_cs, prv_rd, prv_wr, prv_a;
  logic [DATA_W-1:0] prv_data;

  assign cur_rd   = pipe[SYNC_STAGES-1][B_RD];
  assign cur_wr   = pipe[SYNC_STAGES-1][B_WR];
  assign cur_a    = pipe[SYNC_STAGES-1][B_A];
  assign prv_cs   = pipe[SYNC_STAGES][B_CS];
  assign prv_rd   = pipe[SYNC_STAGES][B_RD];
  assign prv_wr   = pipe[SYNC_STAGES][B_WR];
  assign prv_a    = pipe[SYNC_STAGES][B_A];
  assign prv_data = pipe[SYNC_STAGES][DATA_W-1:0];

  logic par, idx_mode, lat_mode;
  assign par      = ~mode_sel[1];
  assign idx_mode = (mode_sel == 2'b00);
  assign lat_mode = (mode_sel == 2'b01);

  logic wr_rise, rd_rise, ale_fall, ptr_evt, dat_wr, dat_rd;
  assign wr_rise  = par & ~prv_cs & ~prv_wr & cur_wr;
  assign rd_rise  = par & ~prv_cs & ~prv_rd & cur_rd;
  assign ale_fall = lat_mode & prv_a & ~cur_a;
  assign ptr_evt  = (wr_rise & idx_mode & prv_a) | ale_fall;
  assign dat_wr   = wr_rise & (lat_mode | ~prv_a);
  assign dat_rd   = rd_rise & (lat_mode | ~prv_a);

  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] din, dout;
  logic              we_q, re_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      din  <= '0;
      dout <= '0;
      we_q <= 1'b0;
      re_q <= 1'b0;
    end else begin
      if (ptr_evt) ptr <= prv_data[ADDR_W-1:0];
      if (dat_wr)  din <= prv_data;
      if (re_q)    dout <= rf_rdata;
      we_q <= dat_wr;
      re_q <= ptr_evt | dat_rd | we_q;
    end
  end

  assign rf_addr  = ptr;
  assign rf_wdata = din;
  assign rf_we    = we_q;
  assign rf_re    = re_q;
  assign bus_out  = dout;
  assign bus_oe   = par & ~cs_n & ~rd_n;

endmodule

// File: rtl/host_reg_port_chk.sv
module host_reg_port_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_sel,
  input logic              cs_n,
  input logic              rd_n,
  input logic              bus_oe,
  input logic              rf_we,
  input logic              rf_re,
  input logic [ADDR_W-1:0] rf_addr,
  input logic [DATA_W-1:0] bus_out
);

  AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> (!cs_n && !rd_n && !mode_sel[1])); // R2
  AST_SERIAL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) mode_sel[1] |-> !bus_oe); // R9
  AST_SINGLE_WE: assert property (@(posedge clk) disable iff (!rst_n) rf_we |=> !rf_we); // R4
  AST_RELOAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) rf_we |=> rf_re); // R5
  AST_PREFETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !rf_re |=> $stable(bus_out)); // R6
  AST_PTR_STABLE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) rf_we |=> $stable(rf_addr)); // R7

endmodule

bind host_reg_port host_reg_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .rd_n(rd_n),
  .bus_oe(bus_oe), .rf_we(rf_we), .rf_re(rf_re), .rf_addr(rf_addr), .bus_out(bus_out)
);

// File: tb/host_reg_port_tb.sv
`timescale 1ns/1ps
module host_reg_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0_ale = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out, rf_wdata, rf_rdata;
  logic       bus_oe, rf_we, rf_re;
  logic [5:0] rf_addr;

  logic [7:0] mem [64];
  logic       poke_en = 1'b0;
  logic [5:0] poke_addr = '0;
  logic [7:0] poke_data = '0;
  int we_cnt = 0, re_cnt = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  host_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .a0_ale(a0_ale), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we),
    .rf_re(rf_re), .rf_rdata(rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (poke_en) mem[poke_addr] <= poke_data;
    else if (rf_we) mem[rf_addr] <= rf_wdata;
    if (rf_we) we_cnt <= we_cnt + 1;
    if (rf_re) re_cnt <= re_cnt + 1;
  end
  assign rf_rdata = mem[rf_addr];

  function automatic logic [7:0] pat(input int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); poke_en = 1'b1; poke_addr = a; poke_data = d;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic bus_write(input logic sel, input logic [7:0] d, input logic cs);
    @(negedge clk); a0_ale = sel; bus_in = d; cs_n = cs; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1;
    idle(2);
    cs_n = 1'b1; a0_ale = 1'b0; bus_in = 8'h00;
    idle(8);
  endtask

  task automatic bus_read(input logic sel, output logic [7:0] d, output logic oe);
    @(negedge clk); a0_ale = sel; cs_n = 1'b0; rd_n = 1'b0;
    idle(2);
    d = bus_out; oe = bus_oe;
    rd_n = 1'b1;
    idle(1);
    cs_n = 1'b1; a0_ale = 1'b0;
    idle(8);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic oe;
    chk("R1 oe idle", bus_oe, 1'b0);
    chk("R1 pointer", rf_addr, 6'd0);
    chk("R1 no strobes", we_cnt + re_cnt, 0);
    bus_read(1'b0, d, oe);
    chk("R1 prefetch reset value", d, 8'h00);
    chk("R2 oe during read", oe, 1'b1);
  endtask

  task automatic t_pointer;
    logic [7:0] d; logic oe;
    bus_write(1'b1, 8'hEA, 1'b0);
    chk("R3 pointer low bits", rf_addr, 6'h2A);
    bus_read(1'b0, d, oe);
    chk("R3 reload after pointer", d, pat(6'h2A));
  endtask

  task automatic t_write;
    logic [7:0] d; logic oe; int w0;
    w0 = we_cnt;
    @(negedge clk); a0_ale = 1'b0; bus_in = 8'h5C; cs_n = 1'b0; wr_n = 1'b0;
    idle(6);
    chk("R4 no commit while strobe low", we_cnt, w0);
    wr_n = 1'b1; idle(2); cs_n = 1'b1; bus_in = 8'h00; idle(8);
    chk("R4 one write pulse", we_cnt, w0 + 1);
    chk("R4 memory content", mem[6'h2A], 8'h5C);
    bus_read(1'b0, d, oe);
    chk("R5 read after write", d, 8'h5C);
  endtask

  task automatic t_stale;
    logic [7:0] d; logic oe;
    poke(6'h2A, 8'h91);
    bus_read(1'b0, d, oe);
    chk("R6 stale prefetch", d, 8'h5C);
    bus_read(1'b0, d, oe);
    chk("R6 reloaded after read", d, 8'h91);
  endtask

  task automatic t_burst;
    logic [7:0] d; logic oe; int w0;
    bus_write(1'b1, 8'h10, 1'b0);
    w0 = we_cnt;
    bus_write(1'b0, 8'h11, 1'b0);
    bus_write(1'b0, 8'h22, 1'b0);
    bus_write(1'b0, 8'h33, 1'b0);
    chk("R7 pointer kept", rf_addr, 6'h10);
    chk("R7 three writes", we_cnt, w0 + 3);
    bus_read(1'b0, d, oe);
    bus_read(1'b0, d, oe);
    chk("R7 last burst value", d, 8'h33);
    chk("R7 pointer after reads", rf_addr, 6'h10);
    bus_write(1'b1, 8'h11, 1'b0);
    bus_read(1'b0, d, oe);
    chk("R7 neighbour untouched", d, pat(6'h11));
  endtask

  task automatic t_oe;
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; idle(1);
    chk("R2 cs only", bus_oe, 1'b0);
    cs_n = 1'b1; rd_n = 1'b0; idle(1);
    chk("R2 rd only", bus_oe, 1'b0);
    rd_n = 1'b1; idle(8);
  endtask

  task automatic t_cs_high;
    logic [7:0] d; logic oe; int w0, r0;
    w0 = we_cnt; r0 = re_cnt;
    bus_write(1'b0, 8'hEE, 1'b1);
    bus_write(1'b1, 8'h05, 1'b1);
    chk("R10 no write", we_cnt, w0);
    chk("R10 no reload", re_cnt, r0);
    chk("R10 pointer kept", rf_addr, 6'h11);
    bus_read(1'b0, d, oe);
    chk("R10 register intact", d, pat(6'h11));
  endtask

  task automatic t_reserved;
    logic [7:0] d; logic oe; int r0;
    r0 = re_cnt;
    bus_read(1'b1, d, oe);
    chk("R11 no reload on reserved read", re_cnt, r0);
  endtask

  task automatic t_latch;
    logic [7:0] d; logic oe; int w0;
    mode_sel = 2'b01; idle(4);
    @(negedge clk); a0_ale = 1'b1; bus_in = 8'h13; idle(3);
    a0_ale = 1'b0; idle(1); bus_in = 8'h00; idle(8);
    chk("R8 latched pointer", rf_addr, 6'h13);
    bus_read(1'b0, d, oe);
    chk("R8 read at latched address", d, pat(6'h13));
    w0 = we_cnt;
    bus_write(1'b0, 8'hA7, 1'b0);
    chk("R8 write pulse", we_cnt, w0 + 1);
    chk("R8 memory content", mem[6'h13], 8'hA7);
    bus_read(1'b0, d, oe);
    chk("R8 read back", d, 8'hA7);
  endtask

  task automatic t_serial;
    logic [7:0] d; logic oe; int w0, r0;
    for (int m = 2; m < 4; m++) begin
      mode_sel = 2'(m); idle(4);
      w0 = we_cnt; r0 = re_cnt;
      bus_write(1'b1, 8'h3F, 1'b0);
      bus_write(1'b0, 8'h77, 1'b0);
      bus_read(1'b0, d, oe);
      chk("R9 no bus drive", oe, 1'b0);
      chk("R9 no write", we_cnt, w0);
      chk("R9 no reload", re_cnt, r0);
      chk("R9 pointer kept", rf_addr, 6'h13);
    end
    mode_sel = 2'b00; idle(4);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) poke(6'(i), pat(i));
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_pointer;
    t_write;
    t_stale;
    t_burst;
    t_oe;
    t_cs_high;
    t_reserved;
    t_latch;
    t_serial;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule